// File: doc/BRIEF.md
# Fetch Sampling Unit

This unit picks one instruction fetch at regular intervals and records what happened to it. It counts completed fetches against a programmable interval. When the interval is used up, it waits for the next fetch to be issued and tags it by its identifier. It then follows that fetch until a completion or an abort with a matching identifier arrives.

At that point it captures a sample and pulses an interrupt. The sample holds the timestamp, the running process ID, the virtual fetch address, the event flags, whether the fetch was aborted, and the fetch latency in cycles. The sample stays valid and frozen until software acknowledges it, and only then does counting resume.

The controller is a four-state machine:
- `ST_COUNT` counts completions.
- `ST_ARMED` waits for the next issue.
- `ST_TRACK` follows the tagged fetch.
- `ST_HOLD` presents the sample.

The transitions are:
- COUNT→ARMED when the interval is reached.
- ARMED→TRACK on an issue.
- TRACK→HOLD on the matching end.
- HOLD→COUNT on acknowledge.
- ARMED/TRACK→COUNT when sampling is disabled (the count restarts from zero).

Top module: `fetch_sampler`

## Requirements
- R1: After reset, `sample_valid` and `sample_irq` are 0 and every sample field is 0.
- R2: With sampling active, each cycle with `fetch_done`=1 in the counting state advances the interval count. On the completion that brings the count to `period`, the unit arms, and the next `fetch_issue` is tagged with its `issue_id` and `issue_addr`. An issue before that point is not tagged.
- R3: While tracking, a `fetch_done` or `fetch_abort` whose `end_id` differs from the tagged ID has no effect. Only a matching end finishes tracking.
- R4: On the capture edge, `smp_timestamp` takes `timestamp`, `smp_pid` takes `cur_pid` and `smp_flags` takes `end_flags`. `smp_addr` is the address latched when the fetch was tagged.
- R5: `smp_aborted` is 1 when the ending strobe includes `fetch_abort`, including when `fetch_done` is also high. It is 0 for a plain completion.
- R6: `smp_latency` equals the number of clock edges from the tagging edge to the capture edge, so its minimum is 1.
- R7: `sample_valid` rises on the capture edge. `sample_irq` is high for exactly the first cycle of `sample_valid`.
- R8: While `sample_valid`=1 and no acknowledge arrives, the sample fields stay unchanged. In that time issues are not tagged and completions do not advance the count.
- R9: `sample_ack`=1 while valid clears `sample_valid` on the next edge, and interval counting resumes from zero.
- R10: Sampling is active only when `enable`=1 and `period`≠0. While inactive, the count holds and nothing is tagged or captured. Becoming inactive while armed or tracking returns the unit to counting with the count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Sampling enable |
| period | input | CNT_W | Completions per sampling interval; 0 disables |
| fetch_issue | input | 1 | A fetch is issued this cycle |
| issue_id | input | ID_W | Identifier of the issued fetch |
| issue_addr | input | ADDR_W | Virtual address of the issued fetch |
| fetch_done | input | 1 | A fetch completes this cycle |
| fetch_abort | input | 1 | A fetch aborts this cycle |
| end_id | input | ID_W | Identifier of the completing or aborting fetch |
| end_flags | input | FLAG_W | Event flags of the ending fetch |
| cur_pid | input | PID_W | Current process ID |
| timestamp | input | TS_W | Free-running time value |
| sample_ack | input | 1 | Software acknowledge of the held sample |
| sample_valid | output | 1 | A sample is held |
| sample_irq | output | 1 | One-cycle interrupt pulse on capture |
| smp_timestamp | output | TS_W | Captured timestamp |
| smp_pid | output | PID_W | Captured process ID |
| smp_addr | output | ADDR_W | Captured fetch address |
| smp_flags | output | FLAG_W | Captured event flags |
| smp_aborted | output | 1 | 1 = fetch aborted, 0 = completed |
| smp_latency | output | LAT_W | Cycles from tag to end |

## Verification
The hardest situation to reach is disabling sampling while a fetch is tagged, then re-enabling it while the old tagged fetch still ends. That stale end must count as an ordinary completion and must not produce a sample. The stimulus drops `enable` for one cycle between the tagging issue and the end of that fetch, then continues the interval so that the next fetch is tagged instead. A second stressed path is the held state: completions and issues arrive while the sample waits, and an end carries both strobes at once. A behavioural model compares every output on every clock.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_ARMED = 2'd1,
        ST_TRACK = 2'd2,
        ST_HOLD  = 2'd3
    } fsp_state_e;
endpackage

// File: rtl/fsp_period_ctr.sv
module fsp_period_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [CNT_W-1:0] period,
    output logic             reached
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt} + 1'b1;
    assign reached  = advance && (cnt_next >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear || reached)
            cnt <= '0;
        else if (advance)
            cnt <= cnt_next[CNT_W-1:0];
    end

    // R8 / R10: without advance or clear, the count holds
    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> $stable(cnt));
endmodule

// File: rtl/fsp_tag_track.sv
module fsp_tag_track #(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32,
    parameter int LAT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [ID_W-1:0]   new_id,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic              end_any,
    input  logic [ID_W-1:0]   end_id,
    output logic              end_hit,
    output logic [ADDR_W-1:0] tag_addr,
    output logic [LAT_W-1:0]  lat
);
    localparam logic [LAT_W-1:0] LAT_MAX = '1;
    logic [ID_W-1:0] tag_id;

    assign end_hit = run && end_any && (end_id == tag_id);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_id   <= '0;
            tag_addr <= '0;
            lat      <= '0;
        end else if (load) begin
            tag_id   <= new_id;
            tag_addr <= new_addr;
            lat      <= LAT_W'(1);
        end else if (run && lat != LAT_MAX) begin
            lat <= lat + 1'b1;
        end
    end
endmodule

// File: rtl/fsp_sample_reg.sv
module fsp_sample_reg #(
    parameter int TS_W   = 32,
    parameter int PID_W  = 16,
    parameter int ADDR_W = 32,
    parameter int FLAG_W = 8,
    parameter int LAT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [TS_W-1:0]   in_ts,
    input  logic [PID_W-1:0]  in_pid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [FLAG_W-1:0] in_flags,
    input  logic              in_aborted,
    input  logic [LAT_W-1:0]  in_lat,
    output logic [TS_W-1:0]   q_ts,
    output logic [PID_W-1:0]  q_pid,
    output logic [ADDR_W-1:0] q_addr,
    output logic [FLAG_W-1:0] q_flags,
    output logic              q_aborted,
    output logic [LAT_W-1:0]  q_lat
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_ts      <= '0;
            q_pid     <= '0;
            q_addr    <= '0;
            q_flags   <= '0;
            q_aborted <= 1'b0;
            q_lat     <= '0;
        end else if (capture) begin
            q_ts      <= in_ts;
            q_pid     <= in_pid;
            q_addr    <= in_addr;
            q_flags   <= in_flags;
            q_aborted <= in_aborted;
            q_lat     <= in_lat;
        end
    end
endmodule

// File: rtl/fetch_sampler.sv
module fetch_sampler
    import fsp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32,
    parameter int FLAG_W = 8,
    parameter int PID_W  = 16,
    parameter int TS_W   = 32,
    parameter int LAT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  period,
    input  logic              fetch_issue,
    input  logic [ID_W-1:0]   issue_id,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              fetch_done,
    input  logic              fetch_abort,
    input  logic [ID_W-1:0]   end_id,
    input  logic [FLAG_W-1:0] end_flags,
    input  logic [PID_W-1:0]  cur_pid,
    input  logic [TS_W-1:0]   timestamp,
    input  logic              sample_ack,
    output logic              sample_valid,
    output logic              sample_irq,
    output logic [TS_W-1:0]   smp_timestamp,
    output logic [PID_W-1:0]  smp_pid,
    output logic [ADDR_W-1:0] smp_addr,
    output logic [FLAG_W-1:0] smp_flags,
    output logic              smp_aborted,
    output logic [LAT_W-1:0]  smp_latency
);
    fsp_state_e state, state_nx;
    logic active, reached, advance, clear_cnt;
    logic tag_load, tracking, end_hit, capture;
    logic [ADDR_W-1:0] tag_addr;
    logic [LAT_W-1:0]  lat;

    assign active    = enable && (period != '0);
    assign advance   = (state == ST_COUNT) && active && fetch_done;
    assign clear_cnt = (state != ST_COUNT) && (state_nx == ST_COUNT);
    assign tag_load  = (state == ST_ARMED) && active && fetch_issue;
    assign tracking  = (state == ST_TRACK);
    assign capture   = tracking && active && end_hit;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COUNT: if (reached) state_nx = ST_ARMED;
            ST_ARMED: begin
                if (!active)          state_nx = ST_COUNT;
                else if (fetch_issue) state_nx = ST_TRACK;
            end
            ST_TRACK: begin
                if (!active)      state_nx = ST_COUNT;
                else if (end_hit) state_nx = ST_HOLD;
            end
            ST_HOLD: if (sample_ack) state_nx = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_COUNT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sample_irq <= 1'b0;
        else        sample_irq <= capture;
    end

    assign sample_valid = (state == ST_HOLD);

    fsp_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clear(clear_cnt), .advance(advance),
        .period(period), .reached(reached)
    );

    fsp_tag_track #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .load(tag_load), .run(tracking),
        .new_id(issue_id), .new_addr(issue_addr),
        .end_any(fetch_done || fetch_abort), .end_id(end_id),
        .end_hit(end_hit), .tag_addr(tag_addr), .lat(lat)
    );

    fsp_sample_reg #(.TS_W(TS_W), .PID_W(PID_W), .ADDR_W(ADDR_W),
                     .FLAG_W(FLAG_W), .LAT_W(LAT_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .in_ts(timestamp), .in_pid(cur_pid), .in_addr(tag_addr),
        .in_flags(end_flags), .in_aborted(fetch_abort), .in_lat(lat),
        .q_ts(smp_timestamp), .q_pid(smp_pid), .q_addr(smp_addr),
        .q_flags(smp_flags), .q_aborted(smp_aborted), .q_lat(smp_latency)
    );

    assert_irq_first_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_irq |-> (sample_valid && !$past(sample_valid)));
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !sample_ack) |=>
            (sample_valid && $stable(smp_addr) && $stable(smp_timestamp) && $stable(smp_latency)));
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && sample_ack) |=> !sample_valid);
    assert_latency_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (smp_latency != '0));
    assert_disabled_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> !sample_irq);
endmodule

// File: tb/fetch_sampler_test.sv
`timescale 1ns/1ps
module fetch_sampler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] period = '0;
    logic        fetch_issue = 1'b0;
    logic [3:0]  issue_id = '0;
    logic [31:0] issue_addr = '0;
    logic        fetch_done = 1'b0;
    logic        fetch_abort = 1'b0;
    logic [3:0]  end_id = '0;
    logic [7:0]  end_flags = '0;
    logic [15:0] cur_pid = '0;
    logic [31:0] timestamp = '0;
    logic        sample_ack = 1'b0;
    logic        sample_valid, sample_irq, smp_aborted;
    logic [31:0] smp_timestamp, smp_addr;
    logic [15:0] smp_pid, smp_latency;
    logic [7:0]  smp_flags;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;
    always @(posedge clk) timestamp <= timestamp + 1;

    fetch_sampler uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
        .fetch_issue(fetch_issue), .issue_id(issue_id), .issue_addr(issue_addr),
        .fetch_done(fetch_done), .fetch_abort(fetch_abort), .end_id(end_id),
        .end_flags(end_flags), .cur_pid(cur_pid), .timestamp(timestamp),
        .sample_ack(sample_ack), .sample_valid(sample_valid), .sample_irq(sample_irq),
        .smp_timestamp(smp_timestamp), .smp_pid(smp_pid), .smp_addr(smp_addr),
        .smp_flags(smp_flags), .smp_aborted(smp_aborted), .smp_latency(smp_latency)
    );

    // behavioural reference
    int  m_mode = 0;      // 0 counting, 1 waiting for issue, 2 following, 3 holding
    int  m_cnt = 0;
    int  m_tid = 0;
    longint m_taddr = 0, m_lat = 0;
    bit  m_valid = 0, m_irq = 0, m_ab = 0;
    longint m_ts = 0, m_pid = 0, m_addr = 0, m_flags = 0, m_slat = 0;

    always @(posedge clk) begin
        bit on;
        on = enable && (period != 0);
        m_irq = 0;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_tid = 0; m_taddr = 0; m_lat = 0; m_valid = 0;
            m_ts = 0; m_pid = 0; m_addr = 0; m_flags = 0; m_ab = 0; m_slat = 0;
        end else if (m_mode == 0) begin
            if (on && fetch_done) begin
                m_cnt++;
                if (m_cnt >= period) begin m_cnt = 0; m_mode = 1; end
            end
        end else if (m_mode == 1) begin
            if (!on) begin m_mode = 0; m_cnt = 0; end
            else if (fetch_issue) begin
                m_tid = issue_id; m_taddr = issue_addr; m_lat = 1; m_mode = 2;
            end
        end else if (m_mode == 2) begin
            if (!on) begin m_mode = 0; m_cnt = 0; end
            else if ((fetch_done || fetch_abort) && end_id == m_tid) begin
                m_ts = timestamp; m_pid = cur_pid; m_addr = m_taddr;
                m_flags = end_flags; m_ab = fetch_abort; m_slat = m_lat;
                m_valid = 1; m_irq = 1; m_mode = 3;
            end else m_lat++;
        end else begin
            if (sample_ack) begin m_valid = 0; m_mode = 0; m_cnt = 0; end
        end
    end

    task automatic expect_eq(string tag, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n && !finished) begin
        expect_eq("R7 valid vs model", sample_valid, m_valid);
        expect_eq("R7 irq vs model", sample_irq, m_irq);
        expect_eq("R4 address vs model", smp_addr, m_addr);
        expect_eq("R4 timestamp vs model", smp_timestamp, m_ts);
        expect_eq("R4 pid vs model", smp_pid, m_pid);
        expect_eq("R4 flags vs model", smp_flags, m_flags);
        expect_eq("R5 outcome vs model", smp_aborted, m_ab);
        expect_eq("R6 latency vs model", smp_latency, m_slat);
    end

    task automatic step(bit iss, int iid, longint ia, bit dn, bit ab, int eid, int fl);
        fetch_issue = iss; issue_id = 4'(iid); issue_addr = 32'(ia);
        fetch_done = dn; fetch_abort = ab; end_id = 4'(eid); end_flags = 8'(fl);
        @(posedge clk); #1;
        fetch_issue = 0; fetch_done = 0; fetch_abort = 0; sample_ack = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        expect_eq("R1 valid after reset", sample_valid, 0);
        expect_eq("R1 irq after reset", sample_irq, 0);
        expect_eq("R1 fields after reset", smp_addr | smp_timestamp | smp_latency, 0);
        rst_n = 1;
        enable = 1; period = 3; cur_pid = 16'h0007;
        // R2: third completion arms; earlier issue not tagged
        step(0, 0, 0, 1, 0, 1, 0);
        step(0, 0, 0, 1, 0, 2, 0);
        step(1, 3, 32'h100, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 3, 0);
        step(1, 9, 32'hA000, 0, 0, 0, 0);
        // R3: non-matching ends ignored
        step(0, 0, 0, 1, 0, 4, 8'hFF);
        step(0, 0, 0, 0, 1, 5, 8'hEE);
        expect_eq("R3 no sample on foreign end", sample_valid, 0);
        idle(1);
        cur_pid = 16'h0042;
        step(0, 0, 0, 1, 0, 9, 8'h5A);
        expect_eq("R2 tagged address", smp_addr, 32'hA000);
        expect_eq("R6 latency four", smp_latency, 4);
        expect_eq("R5 completed", smp_aborted, 0);
        expect_eq("R4 pid at end", smp_pid, 16'h0042);
        expect_eq("R4 flags at end", smp_flags, 8'h5A);
        expect_eq("R7 irq first cycle", sample_irq, 1);
        // R8 hold: activity ignored
        step(0, 0, 0, 1, 0, 1, 0);
        expect_eq("R7 irq one cycle", sample_irq, 0);
        step(1, 2, 32'hB000, 1, 0, 2, 0);
        step(0, 0, 0, 1, 0, 9, 8'h11);
        expect_eq("R8 still valid", sample_valid, 1);
        expect_eq("R8 address frozen", smp_addr, 32'hA000);
        // R9 acknowledge
        sample_ack = 1;
        step(0, 0, 0, 0, 0, 0, 0);
        expect_eq("R9 ack clears valid", sample_valid, 0);
        // R5 both strobes, latency one
        step(0, 0, 0, 1, 0, 1, 0);
        step(0, 0, 0, 1, 0, 2, 0);
        step(0, 0, 0, 1, 0, 3, 0);
        step(1, 6, 32'hC000, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 6, 8'h3C);
        expect_eq("R5 abort wins", smp_aborted, 1);
        expect_eq("R6 latency one", smp_latency, 1);
        expect_eq("R9 sampling resumed", smp_addr, 32'hC000);
        sample_ack = 1;
        step(0, 0, 0, 0, 0, 0, 0);
        // R10 enable gating
        period = 2;
        step(0, 0, 0, 1, 0, 1, 0);
        enable = 0;
        step(0, 0, 0, 1, 0, 2, 0);
        step(0, 0, 0, 1, 0, 3, 0);
        step(1, 4, 32'hBAD0, 0, 0, 0, 0);
        enable = 1;
        step(0, 0, 0, 1, 0, 4, 0);
        step(1, 3, 32'hD000, 0, 0, 0, 0);
        enable = 0;
        step(0, 0, 0, 0, 0, 0, 0);
        enable = 1;
        step(0, 0, 0, 1, 0, 3, 8'h77);
        expect_eq("R10 stale end not sampled", sample_valid, 0);
        step(0, 0, 0, 1, 0, 5, 0);
        step(1, 4, 32'hE000, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 4, 8'h22);
        expect_eq("R10 restart tags next fetch", smp_addr, 32'hE000);
        sample_ack = 1;
        step(0, 0, 0, 0, 0, 0, 0);
        // R10 period zero
        period = 0;
        for (int i = 0; i < 6; i++) step(1, i, 32'hF000 + i, 1, 0, i, 0);
        expect_eq("R10 period zero idle", sample_valid, 0);
        idle(2);
        summary();
    end
endmodule